// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block produces the instruction fetch address for a small in-order 32-bit core that has one architectural branch delay slot. It keeps two addresses of its own: the address being fetched, and the address of the instruction that sits in decode. Every cycle the decode stage gives it the resolved control-flow fields of that instruction: a control flag, a two-bit kind, two operand values, a 16-bit branch displacement, a 26-bit jump index and an annul flag. The block decides the next fetch address.

A redirect always takes effect one fetch later than the branch. In the cycle a branch sits in decode, the instruction behind it (the delay slot) is already being fetched. The target therefore becomes the fetch address on the following edge. When an annulling branch falls through, the block raises a squash output for the cycle in which the delay-slot instruction is in decode, so that the pipeline can discard it. A branch or jump that itself sits in a delay slot has undefined meaning. The block flags it and does not follow it.

The surrounding pipeline must present, in each cycle, the fields of the instruction fetched on the previous accepted edge. A stall freezes every register in the block.

Top module: `nps_seq`

## Requirements
- R1: While the synchronous active-high reset is asserted at a clock edge, the fetch address becomes 0x00000000, slot_squash and slot_err become 0, and decode is marked empty, so any pending slot state is cleared.
- R2: On an edge with stall low where no redirect is taken, the fetch address increases by 4.
- R3: On an edge with stall high, fetch_pc, slot_squash and slot_err keep their values, and no state moves.
- R4: Kind 0 (equal compare) is taken when opnd_a equals opnd_b. A taken branch at address A is followed by the fetch of A+4 and then by A+4+(sign-extended br_off shifted left by 2).
- R5: A branch at A that is not taken is followed by the fetches A+4 and then A+8.
- R6: Kind 1 (non-zero test) is taken when opnd_a is not zero. Its target is formed as in R4.
- R7: Kind 2 (jump) is always taken. Its target is bits 31:28 of the delay-slot address (A+4), then jmp_idx, then two zero bits.
- R8: When a branch with annul set falls through, slot_squash is 1 for exactly the cycle in which its delay slot is in decode. When such a branch is taken, slot_squash stays 0.
- R9: A squashed delay-slot instruction is ignored: a control transfer in it neither redirects nor raises slot_err.
- R10: A control transfer in an unsquashed delay slot raises slot_err for the following cycle, and its redirect is ignored. slot_err and slot_squash are never 1 together.
- R11: In the first cycle after reset, decode is empty and the control inputs have no effect.
- R12: Kind 3 with ctl_en set is treated as an ordinary instruction. It is not a control transfer, and it makes the next instruction no delay slot.
- R13: The fetch address always has its two low bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze all state for this cycle |
| ctl_en | input | 1 | Instruction in decode is a branch or jump |
| ctl_kind | input | 2 | 0 equal, 1 non-zero, 2 jump, 3 none |
| opnd_a | input | 32 | First compared operand |
| opnd_b | input | 32 | Second compared operand |
| br_off | input | 16 | Branch word displacement |
| jmp_idx | input | 26 | Jump word index |
| annul | input | 1 | Squash the delay slot if the branch falls through |
| fetch_pc | output | 32 | Address fetched this cycle |
| slot_squash | output | 1 | Delay slot in decode must be discarded |
| slot_err | output | 1 | Previous decode was a transfer in a delay slot |

## Verification
Two functions can fall in the same decode cycle: the squash or error decision for a delay slot, and the redirect decision for the instruction in that slot. The bench provokes this by placing a jump inside a squashed slot and a branch inside a normal slot, each directly after the branch that made the slot. It judges the result from the fetch address on the next edge, which must be the sequential one, and from which of slot_squash and slot_err is raised. A stall is also held in the cycle where slot_err is high, to confirm that the flag is held rather than dropped.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [1:0] {
    KIND_EQ   = 2'd0,
    KIND_NEZ  = 2'd1,
    KIND_JMP  = 2'd2,
    KIND_NONE = 2'd3
  } ctl_kind_e;

  typedef struct packed {
    logic is_ctl;
    logic is_br;
    logic taken;
  } ctl_res_t;
endpackage

// File: rtl/nps_cond.sv
module nps_cond
  import nps_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            ctl_en,
  input  ctl_kind_e       kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output ctl_res_t        res
);
  logic eq_hit;
  logic nz_hit;

  assign eq_hit = (opa == opb);
  assign nz_hit = |opa;

  always_comb begin
    res = '0;
    if (ctl_en) begin
      unique case (kind)
        KIND_EQ:   begin res.is_ctl = 1'b1; res.is_br = 1'b1; res.taken = eq_hit; end
        KIND_NEZ:  begin res.is_ctl = 1'b1; res.is_br = 1'b1; res.taken = nz_hit; end
        KIND_JMP:  begin res.is_ctl = 1'b1; res.is_br = 1'b0; res.taken = 1'b1;   end
        default:   res = '0;
      endcase
    end
  end
endmodule

// File: rtl/nps_target.sv
module nps_target
  import nps_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  slot_pc,
  input  ctl_kind_e        kind,
  input  logic [OFF_W-1:0] off,
  input  logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  tgt
);
  localparam int SEXT_W = XLEN - OFF_W - 2;
  localparam int HI_W   = XLEN - IDX_W - 2;

  logic [XLEN-1:0] br_disp;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;

  assign br_disp = {{SEXT_W{off[OFF_W-1]}}, off, 2'b00};
  assign br_tgt  = slot_pc + br_disp;

  generate
    if (HI_W > 0) begin : g_region
      assign jmp_tgt = {slot_pc[XLEN-1 -: HI_W], idx, 2'b00};
    end else begin : g_flat
      assign jmp_tgt = {idx, 2'b00};
    end
  endgenerate

  assign tgt = (kind == KIND_JMP) ? jmp_tgt : br_tgt;
endmodule

// File: rtl/nps_state.sv
module nps_state #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [XLEN-1:0] next_pc,
  input  logic            nxt_slot,
  input  logic            nxt_squash,
  input  logic            nxt_err,
  output logic [XLEN-1:0] fetch_pc,
  output logic [XLEN-1:0] dec_pc,
  output logic            dec_vld,
  output logic            slot_q,
  output logic            squash_q,
  output logic            err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= RESET_PC;
      dec_pc   <= RESET_PC;
      dec_vld  <= 1'b0;
      slot_q   <= 1'b0;
      squash_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (!stall) begin
      fetch_pc <= next_pc;
      dec_pc   <= fetch_pc;
      dec_vld  <= 1'b1;
      slot_q   <= nxt_slot;
      squash_q <= nxt_squash;
      err_q    <= nxt_err;
    end
  end
endmodule

// File: rtl/nps_seq.sv
module nps_seq
  import nps_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              OFF_W    = 16,
  parameter int              IDX_W    = 26,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             ctl_en,
  input  logic [1:0]       ctl_kind,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [OFF_W-1:0] br_off,
  input  logic [IDX_W-1:0] jmp_idx,
  input  logic             annul,
  output logic [XLEN-1:0]  fetch_pc,
  output logic             slot_squash,
  output logic             slot_err
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  ctl_kind_e       kind;
  ctl_res_t        res;
  logic [XLEN-1:0] dec_pc;
  logic [XLEN-1:0] slot_pc;
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] next_pc;
  logic            dec_vld;
  logic            slot_q;
  logic            live;
  logic            act;
  logic            redirect;
  logic            nxt_slot;
  logic            nxt_squash;
  logic            nxt_err;

  assign kind    = ctl_kind_e'(ctl_kind);
  assign slot_pc = dec_pc + STEP;

  nps_cond #(.XLEN(XLEN)) u_cond (
    .ctl_en (ctl_en),
    .kind   (kind),
    .opa    (opnd_a),
    .opb    (opnd_b),
    .res    (res)
  );

  nps_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
    .slot_pc (slot_pc),
    .kind    (kind),
    .off     (br_off),
    .idx     (jmp_idx),
    .tgt     (tgt)
  );

  // live: decode holds a real, unsquashed instruction
  assign live       = dec_vld && !slot_squash;
  assign act        = live && res.is_ctl;
  assign redirect   = act && !slot_q && res.taken;
  assign nxt_slot   = act && !slot_q;
  assign nxt_squash = nxt_slot && res.is_br && annul && !res.taken;
  assign nxt_err    = act && slot_q;
  assign next_pc    = redirect ? tgt : fetch_pc + STEP;

  nps_state #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_state (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .next_pc    (next_pc),
    .nxt_slot   (nxt_slot),
    .nxt_squash (nxt_squash),
    .nxt_err    (nxt_err),
    .fetch_pc   (fetch_pc),
    .dec_pc     (dec_pc),
    .dec_vld    (dec_vld),
    .slot_q     (slot_q),
    .squash_q   (slot_squash),
    .err_q      (slot_err)
  );
endmodule

// File: rtl/nps_seq_chk.sv
module nps_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic            ctl_en,
  input logic [XLEN-1:0] fetch_pc,
  input logic            slot_squash,
  input logic            slot_err
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fetch_pc == '0 && !slot_squash && !slot_err));

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!stall && !ctl_en) |=> fetch_pc == $past(fetch_pc) + XLEN'(4));

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(fetch_pc) && $stable(slot_squash) && $stable(slot_err)));

  // R8
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (slot_squash && !stall) |=> !slot_squash);

  // R10
  a_r10_excl: assert property (@(posedge clk) disable iff (rst)
    !(slot_squash && slot_err));

  // R10
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    (slot_err && !stall) |=> !slot_err);

  // R13
  a_r13_align: assert property (@(posedge clk) disable iff (rst)
    fetch_pc[1:0] == 2'b00);
endmodule

bind nps_seq nps_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall       (stall),
  .ctl_en      (ctl_en),
  .fetch_pc    (fetch_pc),
  .slot_squash (slot_squash),
  .slot_err    (slot_err)
);

// File: tb/tb_nps_seq.sv
`timescale 1ns/1ps
module tb_nps_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        ctl_en = 1'b0;
  logic [1:0]  ctl_kind = 2'd3;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_idx = '0;
  logic        annul = 1'b0;
  logic [31:0] fetch_pc;
  logic        slot_squash;
  logic        slot_err;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  nps_seq dut (
    .clk(clk), .rst(rst), .stall(stall), .ctl_en(ctl_en), .ctl_kind(ctl_kind),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off), .jmp_idx(jmp_idx),
    .annul(annul), .fetch_pc(fetch_pc), .slot_squash(slot_squash), .slot_err(slot_err)
  );

  typedef struct packed {
    logic        st;
    logic        en;
    logic [1:0]  kd;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] off;
    logic [25:0] idx;
    logic        an;
    logic [31:0] pc;
    logic        sq;
    logic        er;
  } vec_t;

  localparam int NV = 24;
  // kinds: 0 equal, 1 non-zero, 2 jump, 3 none
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,2'd2,32'd0,32'd0,16'h0000,26'h100,1'b0,32'h04,1'b0,1'b0}, // R11 ignored
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h08,1'b0,1'b0},   // R2
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h0C,1'b0,1'b0},
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h10,1'b0,1'b0},
    '{1'b0,1'b1,2'd0,32'd5,32'd5,16'h0004,26'h0,1'b0,32'h20,1'b0,1'b0},   // R4 taken
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h24,1'b0,1'b0},
    '{1'b0,1'b1,2'd1,32'd0,32'd0,16'h0010,26'h0,1'b0,32'h28,1'b0,1'b0},   // R5 untaken
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h2C,1'b0,1'b0},
    '{1'b0,1'b1,2'd1,32'd7,32'd0,16'hFFFE,26'h0,1'b0,32'h24,1'b0,1'b0},   // R6 backward
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h28,1'b0,1'b0},
    '{1'b0,1'b1,2'd0,32'd1,32'd2,16'h0040,26'h0,1'b1,32'h2C,1'b1,1'b0},   // R8 squash
    '{1'b0,1'b1,2'd2,32'd0,32'd0,16'h0000,26'h40,1'b0,32'h30,1'b0,1'b0},  // R9 ignored
    '{1'b0,1'b1,2'd0,32'd3,32'd3,16'h0008,26'h0,1'b1,32'h50,1'b0,1'b0},   // R8 taken no squash
    '{1'b0,1'b1,2'd1,32'd1,32'd0,16'h0010,26'h0,1'b0,32'h54,1'b0,1'b1},   // R10 err
    '{1'b1,1'b1,2'd2,32'd0,32'd0,16'h0000,26'h40,1'b0,32'h54,1'b0,1'b1},  // R3 stall
    '{1'b0,1'b1,2'd2,32'd0,32'd0,16'h0000,26'h40,1'b0,32'h100,1'b0,1'b0}, // R7
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h104,1'b0,1'b0},
    '{1'b0,1'b1,2'd3,32'd9,32'd9,16'h0040,26'h0,1'b1,32'h108,1'b0,1'b0},  // R12
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h10C,1'b0,1'b0},
    '{1'b0,1'b1,2'd2,32'd0,32'd0,16'h0000,26'h3FFFFFF,1'b0,32'h0FFFFFFC,1'b0,1'b0}, // R7
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h10000000,1'b0,1'b0},
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h10000004,1'b0,1'b0},
    '{1'b0,1'b1,2'd2,32'd0,32'd0,16'h0000,26'h10,1'b0,32'h10000040,1'b0,1'b0}, // R7 region
    '{1'b0,1'b0,2'd3,32'd0,32'd0,16'h0000,26'h0,1'b0,32'h10000044,1'b0,1'b0}
  };

  task automatic check(input string req, input logic [31:0] pc, input logic sq,
                       input logic er);
    total++;
    if (fetch_pc !== pc || slot_squash !== sq || slot_err !== er) begin
      bad++;
      $display("FAIL %s: got pc=%h sq=%b err=%b, want pc=%h sq=%b err=%b",
               req, fetch_pc, slot_squash, slot_err, pc, sq, er);
    end
  endtask

  task automatic drive(input vec_t v);
    stall = v.st; ctl_en = v.en; ctl_kind = v.kd; opnd_a = v.a; opnd_b = v.b;
    br_off = v.off; jmp_idx = v.idx; annul = v.an;
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got hung run, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t q;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R2-R12 vector %0d", i), VEC[i].pc, VEC[i].sq, VEC[i].er);
    end
    // R8: annulled fall-through, then reset while squash is up (R1)
    q = '{1'b0,1'b1,2'd1,32'd0,32'd0,16'h0040,26'h0,1'b1,32'h0,1'b0,1'b0};
    drive(q);
    @(negedge clk);
    check("R8 squash", 32'h10000048, 1'b1, 1'b0);
    ctl_en = 1'b0; annul = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset", 32'h4, 1'b0, 1'b0);
    // R3: stall right after reset holds fetch
    stall = 1'b1;
    @(negedge clk);
    check("R3 stall", 32'h4, 1'b0, 1'b0);
    stall = 1'b0;
    @(negedge clk);
    check("R2 resume", 32'h8, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule